// File: doc/BRIEF.md
# Microcontroller Clock Generation Controller

This block produces every clock enable that the core and its peripherals of a small microcontroller consume. It works from two free-running enable pulses on the system clock. `main_tick` marks each edge of the fast main oscillator, and `sub_tick` marks each edge of the slow 32 kHz-class sub oscillator. A single 9-bit control word chooses the bus clock source and divider. The same word holds the sub oscillator enable, the main oscillator halt, the two oscillator drive-strength flags and the option to gate the peripherals during WAIT. Stop-mode entry and the current power mode decide which of these fields are forced to defaults.

The bus clock enable comes either from the main tick divided by 1, 2, 4, 8 or 16, or from the enabled sub tick. A four-state handover machine changes the source without cutting a period short:

- `SRC_MAIN` moves to `SRC_LEAVE_MAIN` when the sub-clock is requested.
- `SRC_LEAVE_MAIN` moves to `SRC_SUB` on the next divided main pulse. It returns to `SRC_MAIN` if the request is withdrawn.
- `SRC_SUB` moves to `SRC_LEAVE_SUB` when the request drops.
- `SRC_LEAVE_SUB` moves to `SRC_MAIN` on the next sub pulse, or at once if the sub oscillator is off. It returns to `SRC_SUB` if the request comes back.

Three peripheral enables divide the running main tick by 1, 8 and 32. A further enable divides the sub tick by 32 for the timers.

Top module: `clkgen_ctrl`

## Requirements
- R1: After reset `rd_data` is 0x0C3 and the bus clock is the main tick divided by 8. The fields are: bits 2:0 divider code, bit 3 sub-clock select, bit 4 sub oscillator on, bit 5 main stop, bit 6 main drive, bit 7 sub drive, bit 8 WAIT peripheral stop.
- R2: Divider codes 0..4 give one `bclk_en` pulse per 1, 2, 4, 8 or 16 main ticks. Codes 5..7 behave as 16.
- R3: A change of divider code restarts the bus divider, so the first pulse after the change comes on the N-th main tick for the new ratio N.
- R4: The bus clock moves to the sub-clock only when both bit 3 and bit 4 are 1. It waits for the current main period to end first. On return it waits for the current sub period, and the main divider then starts a full new period. `src_is_sub` shows the active source.
- R5: A write setting bit 5 is accepted only while the sub-clock is the active source, and otherwise bit 5 reads back 0. The bit clears when the sub-clock request is dropped.
- R6: `pf1_en`, `pf8_en` and `pf32_en` pulse once per 1, 8 and 32 running main ticks. All three are silent while bit 5 is 1.
- R7: While `wait_exec` is 1 and bit 8 is 1, the three peripheral enables are silent and `bclk_en` is unaffected. With bit 8 at 0, `wait_exec` has no effect.
- R8: `fc_en` equals `sub_tick` while bit 4 is 1 and is 0 otherwise. `fc32_en` pulses once per 32 `fc_en` pulses.
- R9: A `stop_req` with `low_power` at 0 forces bit 6 and bit 7 to 1 and the divider code to 3.
- R10: A `stop_req` with `low_power` at 1 forces bit 7 to 1 and leaves bit 6 and the divider code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_tick | input | 1 | Main oscillator edge pulse |
| sub_tick | input | 1 | Sub oscillator edge pulse |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 9 | Control word write value |
| stop_req | input | 1 | Stop-mode entry pulse |
| low_power | input | 1 | 1 when in low-speed or low-power mode |
| wait_exec | input | 1 | WAIT instruction in progress |
| rd_data | output | 9 | Control word read-back |
| bclk_en | output | 1 | CPU bus clock enable |
| pf1_en | output | 1 | Peripheral enable, main divided by 1 |
| pf8_en | output | 1 | Peripheral enable, main divided by 8 |
| pf32_en | output | 1 | Peripheral enable, main divided by 32 |
| fc_en | output | 1 | Undivided sub-clock enable |
| fc32_en | output | 1 | Sub-clock divided by 32 enable |
| src_is_sub | output | 1 | Sub-clock is the active bus source |

## Verification
The bus divider is driven with main ticks at random spacing for random divider codes. Measuring ticks between pulses separates a correct ratio from a miscounted one, regardless of how the gaps fall. A directed code change in the middle of a period tells a restarted divider from one that keeps its old phase. Source handover is tried with the new source active while the old one is held silent: a machine that switches early shows a pulse there, and one that switches correctly shows none. Stop entry is repeated in both power modes so that forced fields can be told from retained ones.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN       = 2'd0,
        SRC_LEAVE_MAIN = 2'd1,
        SRC_SUB        = 2'd2,
        SRC_LEAVE_SUB  = 2'd3
    } src_state_t;

    localparam int CTL_W   = 9;
    localparam int F_DIV   = 0;
    localparam int F_SEL   = 3;
    localparam int F_SUBON = 4;
    localparam int F_MSTOP = 5;
    localparam int F_MDRV  = 6;
    localparam int F_SDRV  = 7;
    localparam int F_WSTOP = 8;

    localparam logic [2:0]       DIV_DEFAULT = 3'd3;
    localparam logic [CTL_W-1:0] CTL_RESET   = 9'h0C3;

    function automatic logic [2:0] div_log2(input logic [2:0] code);
        return (code > 3'd4) ? 3'd4 : code;
    endfunction

endpackage

// File: rtl/clkgen_div.sv
`timescale 1ns/1ps
module clkgen_div #(
    parameter int CW = 5,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic [LW-1:0] log2r,
    output logic          pulse
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last  = (CW'(1) << log2r) - CW'(1);
    assign pulse = tick && !clr && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == last) ? '0 : cnt + CW'(1);
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt <= last)); // R2

endmodule

// File: rtl/clkgen_regs.sv
`timescale 1ns/1ps
module clkgen_regs
    import clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             stop_req,
    input  logic             low_power,
    input  logic             in_sub,
    output logic [CTL_W-1:0] ctl
);

    logic [CTL_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl;
        if (stop_req) begin
            ctl_d[F_SDRV] = 1'b1;
            if (!low_power) begin
                ctl_d[F_MDRV]        = 1'b1;
                ctl_d[F_DIV +: 3]    = DIV_DEFAULT;
            end
        end else if (wr_en) begin
            ctl_d          = wr_data;
            ctl_d[F_MSTOP] = wr_data[F_MSTOP] && in_sub;
        end
        ctl_d[F_MSTOP] = ctl_d[F_MSTOP] && ctl_d[F_SEL] && ctl_d[F_SUBON];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl <= CTL_RESET;
        else
            ctl <= ctl_d;
    end

    AST_STOP_SUBDRV: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_req) |-> ctl[F_SDRV]); // R9

    AST_LP_KEEP_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && low_power) |=> $stable(ctl[F_DIV +: 3])); // R10

endmodule

// File: rtl/clkgen_switch.sv
`timescale 1ns/1ps
module clkgen_switch
    import clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want_sub,
    input  logic       sub_on,
    input  logic       main_pulse,
    input  logic       sub_pulse,
    output src_state_t state,
    output logic       bclk_en
);

    src_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SRC_MAIN;
        else
            state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            SRC_MAIN:
                if (want_sub) state_d = SRC_LEAVE_MAIN;
            SRC_LEAVE_MAIN:
                if (!want_sub)       state_d = SRC_MAIN;
                else if (main_pulse) state_d = SRC_SUB;
            SRC_SUB:
                if (!want_sub) state_d = SRC_LEAVE_SUB;
            SRC_LEAVE_SUB:
                if (want_sub)                  state_d = SRC_SUB;
                else if (sub_pulse || !sub_on) state_d = SRC_MAIN;
        endcase
    end

    always_comb begin
        unique case (state)
            SRC_MAIN, SRC_LEAVE_MAIN: bclk_en = main_pulse;
            SRC_SUB,  SRC_LEAVE_SUB:  bclk_en = sub_pulse;
        endcase
    end

    AST_HANDOVER_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SRC_SUB && $past(state) == SRC_LEAVE_MAIN) |-> $past(main_pulse)); // R4

    AST_HANDOVER_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SRC_MAIN && $past(state) == SRC_LEAVE_SUB)
            |-> ($past(sub_pulse) || !$past(sub_on))); // R4

endmodule

// File: rtl/clkgen_ctrl.sv
`timescale 1ns/1ps
module clkgen_ctrl
    import clkgen_pkg::*;
#(
    parameter int DIV_CW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_tick,
    input  logic             sub_tick,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             stop_req,
    input  logic             low_power,
    input  logic             wait_exec,
    output logic [CTL_W-1:0] rd_data,
    output logic             bclk_en,
    output logic             pf1_en,
    output logic             pf8_en,
    output logic             pf32_en,
    output logic             fc_en,
    output logic             fc32_en,
    output logic             src_is_sub
);

    localparam int NPF = 3;

    logic [CTL_W-1:0] ctl;
    src_state_t       state;
    logic             main_run, periph_tick, want_sub;
    logic             bus_clr, main_pulse;
    logic [2:0]       div_prev;
    logic [NPF-1:0]   pf_vec;

    assign main_run    = main_tick && !ctl[F_MSTOP];
    assign periph_tick = main_run && !(wait_exec && ctl[F_WSTOP]);
    assign fc_en       = sub_tick && ctl[F_SUBON];
    assign want_sub    = ctl[F_SEL] && ctl[F_SUBON];
    assign src_is_sub  = (state == SRC_SUB) || (state == SRC_LEAVE_SUB);
    assign rd_data     = ctl;
    assign bus_clr     = (ctl[F_DIV +: 3] != div_prev) || src_is_sub;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_prev <= DIV_DEFAULT;
        else
            div_prev <= ctl[F_DIV +: 3];
    end

    clkgen_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .stop_req  (stop_req),
        .low_power (low_power),
        .in_sub    (state == SRC_SUB),
        .ctl       (ctl)
    );

    clkgen_div #(.CW(DIV_CW), .LW(3)) u_bus_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (main_run),
        .clr   (bus_clr),
        .log2r (div_log2(ctl[F_DIV +: 3])),
        .pulse (main_pulse)
    );

    clkgen_switch u_switch (
        .clk        (clk),
        .rst_n      (rst_n),
        .want_sub   (want_sub),
        .sub_on     (ctl[F_SUBON]),
        .main_pulse (main_pulse),
        .sub_pulse  (fc_en),
        .state      (state),
        .bclk_en    (bclk_en)
    );

    for (genvar g = 0; g < NPF; g++) begin : g_pf
        localparam logic [2:0] PF_LOG = (g == 0) ? 3'd0 : (g == 1) ? 3'd3 : 3'd5;
        clkgen_div #(.CW(DIV_CW), .LW(3)) u_pf_div (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (periph_tick),
            .clr   (1'b0),
            .log2r (PF_LOG),
            .pulse (pf_vec[g])
        );
    end

    assign pf1_en  = pf_vec[0];
    assign pf8_en  = pf_vec[1];
    assign pf32_en = pf_vec[2];

    clkgen_div #(.CW(DIV_CW), .LW(3)) u_fc32_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (fc_en),
        .clr   (1'b0),
        .log2r (3'd5),
        .pulse (fc32_en)
    );

    AST_STOP_WHILE_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[F_MSTOP] |-> (state == SRC_SUB)); // R5

    AST_PF_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[F_MSTOP] |-> !(pf1_en || pf8_en || pf32_en)); // R6

    AST_WAIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_exec && ctl[F_WSTOP]) |-> !(pf1_en || pf8_en || pf32_en)); // R7

    AST_SUB_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[F_SUBON] |-> !fc_en && !fc32_en); // R8

endmodule

// File: tb/clkgen_ctrl_tb.sv
`timescale 1ns/1ps
module clkgen_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_tick = 1'b0, sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       stop_req = 1'b0, low_power = 1'b0, wait_exec = 1'b0;
    logic [8:0] rd_data;
    logic       bclk_en, pf1_en, pf8_en, pf32_en, fc_en, fc32_en, src_is_sub;

    int n_tests = 0, n_fail = 0;
    int c_bclk, c_pf1, c_pf8, c_pf32, c_fc, c_fc32, c_mis, c_fcmis;
    logic s_bclk, s_fc;

    always #2 clk = ~clk;

    clkgen_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
        .wr_en(wr_en), .wr_data(wr_data), .stop_req(stop_req),
        .low_power(low_power), .wait_exec(wait_exec), .rd_data(rd_data),
        .bclk_en(bclk_en), .pf1_en(pf1_en), .pf8_en(pf8_en), .pf32_en(pf32_en),
        .fc_en(fc_en), .fc32_en(fc32_en), .src_is_sub(src_is_sub)
    );

    function automatic int exp_ratio(input int code);
        return (code > 4) ? 16 : (1 << code);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic mt, input logic st);
        @(negedge clk);
        main_tick = mt;
        sub_tick  = st;
        #1;
        s_bclk = bclk_en;
        s_fc   = fc_en;
        c_bclk += int'(bclk_en);
        c_pf1  += int'(pf1_en);
        c_pf8  += int'(pf8_en);
        c_pf32 += int'(pf32_en);
        c_fc   += int'(fc_en);
        c_fc32 += int'(fc32_en);
        if (bclk_en != fc_en) c_mis++;
        if (fc_en != st)      c_fcmis++;
    endtask

    task automatic clr_counts();
        c_bclk = 0; c_pf1 = 0; c_pf8 = 0; c_pf32 = 0;
        c_fc = 0; c_fc32 = 0; c_mis = 0; c_fcmis = 0;
    endtask

    // mode: 0 never, 1 always, 2 random
    task automatic run(input int n, input int mm, input int sm);
        clr_counts();
        for (int i = 0; i < n; i++) begin
            logic mt, st;
            mt = (mm == 1) || (mm == 2 && ($urandom % 2) == 1);
            st = (sm == 1) || (sm == 2 && ($urandom % 2) == 1);
            cyc(mt, st);
        end
    endtask

    task automatic wr(input logic [8:0] d);
        wr_en = 1'b1;
        wr_data = d;
        cyc(1'b0, 1'b0);
        wr_en = 1'b0;
    endtask

    task automatic stop_pulse(input logic lp);
        low_power = lp;
        stop_req = 1'b1;
        cyc(1'b0, 1'b0);
        stop_req = 1'b0;
    endtask

    // ticks to first bus pulse and ticks between first and second
    task automatic measure(output int first, output int gap);
        int tk = 0, p1 = -1;
        first = -1; gap = -1;
        for (int i = 0; i < 400; i++) begin
            logic mt;
            mt = ($urandom % 2) == 1;
            cyc(mt, 1'b0);
            if (mt) tk++;
            if (s_bclk) begin
                if (p1 < 0) begin p1 = tk; first = tk; end
                else begin gap = tk - p1; break; end
            end
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int first, gap;
        void'($urandom(32'd4242));
        clr_counts();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset word and /8 bus clock
        cyc(1'b0, 1'b0);
        check("R1 reset word", int'(rd_data), 'h0C3);
        measure(first, gap);
        check("R1 first bus pulse at reset", first, 8);
        check("R1 bus ratio at reset", gap, 8);

        // R8: sub oscillator off after reset
        run(20, 0, 1);
        check("R8 fc_en silent when oscillator off", c_fc, 0);

        // R2: random divider codes
        for (int k = 0; k < 8; k++) begin
            int code;
            code = (k == 0) ? 7 : int'($urandom % 8);
            wr(9'h0C0 | 9'(code));
            run(2, 0, 0);
            measure(first, gap);
            check($sformatf("R2 ratio code %0d", code), gap, exp_ratio(code));
        end

        // R3: mid-period code change restarts divider
        wr(9'h0C2);
        run(2, 0, 0);
        measure(first, gap);
        run(2, 1, 0);
        wr(9'h0C4);
        run(2, 0, 0);
        measure(first, gap);
        check("R3 first pulse after change", first, 16);

        // R6 / R7 peripheral dividers and WAIT gating
        wr(9'h0C3);
        run(64, 1, 0);
        check("R6 pf1 count", c_pf1, 64);
        check("R6 pf8 count", c_pf8, 8);
        check("R6 pf32 count", c_pf32, 2);
        wait_exec = 1'b1;
        run(64, 1, 0);
        check("R7 wait without stop bit pf1", c_pf1, 64);
        wr(9'h1C3);
        run(64, 1, 0);
        check("R7 wait gated pf1", c_pf1, 0);
        check("R7 wait gated pf32", c_pf32, 0);
        check("R7 bus clock unaffected by wait", c_bclk, 8);
        wait_exec = 1'b0;
        run(64, 1, 0);
        check("R7 pf8 resumes", c_pf8, 8);

        // R5: stop ignored while main is the source
        wr(9'h0E3);
        check("R5 stop bit reads 0 on main", int'(rd_data[5]), 0);
        run(16, 1, 0);
        check("R5 main still running", c_pf1, 16);

        // R4: select without oscillator stays on main
        wr(9'h0CB);
        run(2, 0, 0);
        measure(first, gap);
        check("R4 no switch without oscillator", gap, 8);
        check("R4 source flag main", int'(src_is_sub), 0);

        // R4: switch to sub waits for main period
        wr(9'h0DB);
        run(10, 0, 1);
        check("R4 no bus pulse before main period ends", c_bclk, 0);
        check("R8 fc_en follows sub_tick", c_fcmis, 0);
        clr_counts();
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, 1'b1);
            if (s_bclk) break;
        end
        check("R4 main period completes", c_bclk, 1);
        run(40, 1, 2);
        check("R4 bus follows sub", c_mis, 0);
        check("R4 source flag sub", int'(src_is_sub), 1);
        run(64, 0, 1);
        check("R8 fc32 count", c_fc32, 2);

        // R5 / R6: main stop accepted on sub
        wr(9'h0FB);
        check("R5 stop bit accepted on sub", int'(rd_data[5]), 1);
        run(32, 1, 0);
        check("R6 peripherals halted by main stop", c_pf1, 0);

        // R4 / R5: return to main
        wr(9'h0D3);
        check("R5 stop bit cleared on return", int'(rd_data[5]), 0);
        run(6, 1, 0);
        check("R4 waits for sub period", c_bclk, 0);
        cyc(1'b1, 1'b1);
        check("R4 last sub pulse", int'(s_bclk), 1);
        run(7, 1, 0);
        check("R4 main full period pending", c_bclk, 0);
        cyc(1'b1, 1'b0);
        check("R4 main pulse on eighth tick", int'(s_bclk), 1);

        // R9 / R10: stop entry
        wr(9'h001);
        stop_pulse(1'b0);
        cyc(1'b0, 1'b0);
        check("R9 stop from high speed", int'(rd_data), 'h0C3);
        wr(9'h001);
        stop_pulse(1'b1);
        cyc(1'b0, 1'b0);
        check("R10 stop from low power", int'(rd_data), 'h081);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule